// File: doc/BRIEF.md
# Write-Back Set-Associative Cache Controller

This block holds a small set-associative cache with write-back storage. The processor side does word, halfword and byte loads and stores in the same cycle it asks for them, with the answer produced combinationally from the stored lines. It also issues line-refill commands that carry an access mode. The memory side is a word-wide request/ready port. The controller claims that port for as long as it moves a line. A store that misses is dropped: lines enter the cache only through an explicit refill.

When a refill is accepted, the controller picks a victim way in the addressed set. If that victim is dirty, the controller streams it out to memory one word at a time. It then streams the requested line in the same way, one word per ready beat. Three event counters track hits, accepted refills and completed write-backs. A synchronous abort drops any line move in progress.

The controller has three named states. `ST_IDLE` goes to `ST_WBACK` when a refill is accepted and the victim needs writing back. `ST_IDLE` goes to `ST_FILL` when a refill is accepted and no write-back is needed. `ST_WBACK` goes to `ST_FILL` on the ready beat of its last word. `ST_FILL` goes to `ST_IDLE` on the ready beat of its last word. From any state, `abort` returns the controller to `ST_IDLE`.

Top module: `wbc_cache`

## Requirements
- R1: An address splits, from the top bit downward, into tag, set index (log2 SETS bits) and byte offset (log2 of 4*LINE_WORDS bits). A processor access hits only when some way of the indexed set both holds that tag and has its valid bit set.
- R2: A load hit returns a zero-extended lane of the addressed word. `cpu_size` selects the lane width: 0 is byte, 1 is halfword, 2 is word. The byte lane is address bits [1:0] and the halfword lane is address bit 1. When `byte_swap` is 1, the lane number is mirrored: byte lane n becomes 3-n, and halfword lane n becomes 1-n. Lane n covers data bits [8n+7:8n] for a byte and [16n+15:16n] for a halfword.
- R3: A refill is accepted only when the controller is idle, `bus_free` is 1 and `abort` is 0. Any other refill is ignored. After an accepted refill, `busy` and `bus_own` rise on the next cycle.
- R4: The victim is the lowest-numbered invalid way of the set. If every way is valid, the victim is the way whose last-access stamp is smallest, and a tie keeps the lowest-numbered way. A stamp takes the value of a free-running cycle counter on every load or store hit and when a refill completes.
- R5: A valid, dirty victim is written back before the refill. The write-back is skipped when `fill_mode` is 1 (instruction fetch) or `isolate` is 1. A `fill_mode` of 0 means data load.
- R6: Write-back and refill each move the line one 32-bit word at a time in ascending address order. Each starts at the line-aligned address. The controller moves to the next word only on a cycle with `mem_rdy` high, and holds `mem_addr` until then.
- R7: When a refill is accepted, the victim line is invalidated. When the refill completes, the new tag is stored, the line becomes valid and clean, the bus is released and the controller returns to idle.
- R8: A misaligned access raises an address error and has no other effect. A word access is misaligned when address bits [1:0] are not 0. A halfword access is misaligned when address bit 0 is 1. A load raises `cpu_adel` and a store raises `cpu_ades`.
- R9: A load that misses returns all ones of the access width (0xFF, 0xFFFF or 0xFFFFFFFF). A store that misses changes nothing.
- R10: A store hit writes only the selected lane, using the same lane rules as R2, and marks the line dirty.
- R11: `hit_count` counts aligned load and store hits. `miss_count` counts accepted refills. `wb_count` counts completed write-backs.
- R12: `abort` returns the controller to idle and releases the bus on the next cycle from any state. A line that was being filled stays invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort | input | 1 | Drop any line move and release the bus |
| byte_swap | input | 1 | Mirror byte and halfword lane numbers |
| isolate | input | 1 | Skip write-back of dirty victims |
| cpu_req | input | 1 | Processor access strobe |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | ADDR_W | Access byte address |
| cpu_wdata | input | 32 | Store data, right-aligned |
| cpu_rdata | output | 32 | Load result |
| cpu_hit | output | 1 | Aligned access hit |
| cpu_adel | output | 1 | Load address error |
| cpu_ades | output | 1 | Store address error |
| fill_req | input | 1 | Refill command strobe |
| fill_mode | input | 1 | 0 data load, 1 instruction fetch |
| fill_addr | input | ADDR_W | Any byte address inside the wanted line |
| busy | output | 1 | Line move in progress |
| bus_free | input | 1 | Memory bus may be claimed this cycle |
| bus_own | output | 1 | Memory bus held by this block |
| mem_req | output | 1 | Word transfer request |
| mem_we | output | 1 | 1 write-back word, 0 refill word |
| mem_addr | output | ADDR_W | Word address of the transfer |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data |
| mem_rdy | input | 1 | Current word completes this cycle |
| hit_count | output | CNT_W | Hit events |
| miss_count | output | CNT_W | Accepted refills |
| wb_count | output | CNT_W | Completed write-backs |

## Verification
Loads are tried at every width, with `byte_swap` both clear and set, so that a mirrored lane reads a different value from the plain one. Refills are sent into a set with a free way, into a full set with a clean oldest line, and into a full set with a dirty oldest line. These three cases separate first-invalid selection, timestamp selection and the write-back path. The same dirty-victim setup is then repeated under instruction mode and under isolate, where a correct design must leave memory untouched. Refills with the bus denied, refills sent while busy, and an abort under a stalled memory show that the ignore paths and the abort path leave the cache and the counters in the expected state.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } wbc_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic MODE_DATA = 1'b0;
    localparam logic MODE_INST = 1'b1;
endpackage

// File: rtl/wbc_hit_find.sv
module wbc_hit_find #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 26,
    parameter int WAY_W = 1
) (
    input  logic [WAYS*TAG_W-1:0] tags,
    input  logic [WAYS-1:0]       valids,
    input  logic [TAG_W-1:0]      tag,
    output logic                  hit,
    output logic [WAY_W-1:0]      way
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = valids[g] && (tags[g*TAG_W +: TAG_W] == tag);
    end

    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (match[i] && !hit) begin
                hit = 1'b1;
                way = WAY_W'(i);
            end
        end
    end
endmodule

// File: rtl/wbc_victim_pick.sv
module wbc_victim_pick #(
    parameter int WAYS  = 2,
    parameter int TS_W  = 16,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]      valids,
    input  logic [WAYS*TS_W-1:0] stamps,
    output logic [WAY_W-1:0]     way
);
    always_comb begin
        logic found;
        int   old;
        found = 1'b0;
        old   = 0;
        way   = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (!valids[i] && !found) begin
                found = 1'b1;
                way   = WAY_W'(i);
            end
        end
        if (!found) begin
            for (int i = 1; i < WAYS; i++) begin
                if (stamps[i*TS_W +: TS_W] < stamps[old*TS_W +: TS_W]) begin
                    old = i;
                end
            end
            way = WAY_W'(old);
        end
    end
endmodule

// File: rtl/wbc_lane.sv
module wbc_lane
    import wbc_pkg::*;
(
    input  logic [1:0]  size,
    input  logic [1:0]  low,
    input  logic        swap,
    input  logic [31:0] word,
    input  logic [31:0] wdata,
    output logic [31:0] load_val,
    output logic [31:0] merged
);
    logic [1:0] bl;
    logic       hl;

    assign bl = swap ? (2'd3 - low) : low;
    assign hl = swap ? ~low[1] : low[1];

    always_comb begin
        merged = word;
        unique case (size)
            SZ_BYTE: begin
                load_val = {24'd0, word[{bl, 3'b000} +: 8]};
                merged[{bl, 3'b000} +: 8] = wdata[7:0];
            end
            SZ_HALF: begin
                load_val = {16'd0, word[{hl, 4'b0000} +: 16]};
                merged[{hl, 4'b0000} +: 16] = wdata[15:0];
            end
            default: begin
                load_val = word;
                merged   = wdata;
            end
        endcase
    end
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WAYS       = 2,
    parameter int SETS       = 4,
    parameter int LINE_WORDS = 4,
    parameter int TS_W       = 16,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              byte_swap,
    input  logic              isolate,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_adel,
    output logic              cpu_ades,
    input  logic              fill_req,
    input  logic              fill_mode,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              busy,
    input  logic              bus_free,
    output logic              bus_own,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_rdy,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count,
    output logic [CNT_W-1:0]  wb_count
);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = WSEL_W + 2;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

    // line storage
    logic [TAG_W-1:0] tag_q   [WAYS][SETS];
    logic             valid_q [WAYS][SETS];
    logic             dirty_q [WAYS][SETS];
    logic [TS_W-1:0]  stamp_q [WAYS][SETS];
    logic [31:0]      data_q  [WAYS][SETS][LINE_WORDS];
    logic [TS_W-1:0]  ts_q;

    // controller registers
    wbc_state_e        state_q, state_d;
    logic [WSEL_W-1:0] cnt_q;
    logic [WAY_W-1:0]  way_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  ltag_q, vtag_q;
    logic [CNT_W-1:0]  hit_q, miss_q, wb_q;

    // processor-side decode
    logic [TAG_W-1:0]      c_tag;
    logic [IDX_W-1:0]      c_idx;
    logic [WSEL_W-1:0]     c_wsel;
    logic [WAYS*TAG_W-1:0] c_tags;
    logic [WAYS-1:0]       c_valids;
    logic                  c_hit, misalign, acc_ok;
    logic [WAY_W-1:0]      c_way;
    logic [31:0]           c_word, load_val, merged;

    assign c_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign c_idx  = cpu_addr[OFF_W +: IDX_W];
    assign c_wsel = cpu_addr[2 +: WSEL_W];

    // refill-side decode
    logic [TAG_W-1:0]     f_tag;
    logic [IDX_W-1:0]     f_idx;
    logic [WAYS-1:0]      f_valids;
    logic [WAYS*TS_W-1:0] f_stamps;
    logic [WAY_W-1:0]     vict;
    logic                 accept, need_wb, last, beat;
    logic                 unused_low;

    assign f_tag      = fill_addr[ADDR_W-1 -: TAG_W];
    assign f_idx      = fill_addr[OFF_W +: IDX_W];
    assign unused_low = ^fill_addr[OFF_W-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_flat
        assign c_tags[w*TAG_W +: TAG_W]  = tag_q[w][c_idx];
        assign c_valids[w]               = valid_q[w][c_idx];
        assign f_valids[w]               = valid_q[w][f_idx];
        assign f_stamps[w*TS_W +: TS_W]  = stamp_q[w][f_idx];
    end

    wbc_hit_find #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_hit (
        .tags(c_tags), .valids(c_valids), .tag(c_tag), .hit(c_hit), .way(c_way)
    );

    wbc_victim_pick #(.WAYS(WAYS), .TS_W(TS_W), .WAY_W(WAY_W)) u_vict (
        .valids(f_valids), .stamps(f_stamps), .way(vict)
    );

    assign c_word = data_q[c_way][c_idx][c_wsel];

    wbc_lane u_lane (
        .size(cpu_size), .low(cpu_addr[1:0]), .swap(byte_swap), .word(c_word),
        .wdata(cpu_wdata), .load_val(load_val), .merged(merged)
    );

    assign misalign = ((cpu_size == SZ_WORD) && (cpu_addr[1:0] != 2'b00)) ||
                      ((cpu_size == SZ_HALF) && cpu_addr[0]);
    assign acc_ok   = cpu_req && !misalign && c_hit;
    assign cpu_hit  = acc_ok;
    assign cpu_adel = cpu_req && !cpu_we && misalign;
    assign cpu_ades = cpu_req && cpu_we && misalign;

    always_comb begin
        if (acc_ok && !cpu_we)          cpu_rdata = load_val;
        else if (cpu_size == SZ_BYTE)   cpu_rdata = 32'h0000_00FF;
        else if (cpu_size == SZ_HALF)   cpu_rdata = 32'h0000_FFFF;
        else                            cpu_rdata = 32'hFFFF_FFFF;
    end

    assign accept  = (state_q == ST_IDLE) && fill_req && bus_free && !abort;
    assign need_wb = valid_q[vict][f_idx] && dirty_q[vict][f_idx] &&
                     (fill_mode == MODE_DATA) && !isolate;
    assign last    = (cnt_q == WSEL_W'(LINE_WORDS - 1));
    assign beat    = mem_req && mem_rdy && !abort;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)        state_d = need_wb ? ST_WBACK : ST_FILL;
            ST_WBACK: if (mem_rdy && last) state_d = ST_FILL;
            ST_FILL:  if (mem_rdy && last) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
        if (abort) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        bus_own   = busy;
        mem_req   = (state_q == ST_WBACK) || (state_q == ST_FILL);
        mem_we    = (state_q == ST_WBACK);
        mem_addr  = mem_we ? {vtag_q, idx_q, cnt_q, 2'b00} : {ltag_q, idx_q, cnt_q, 2'b00};
        mem_wdata = data_q[way_q][idx_q][cnt_q];
    end

    assign hit_count  = hit_q;
    assign miss_count = miss_q;
    assign wb_count   = wb_q;

    // line moves, processor writes and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q   <= '0;
            cnt_q  <= '0;
            way_q  <= '0;
            idx_q  <= '0;
            ltag_q <= '0;
            vtag_q <= '0;
            hit_q  <= '0;
            miss_q <= '0;
            wb_q   <= '0;
            for (int w = 0; w < WAYS; w++) begin
                for (int s = 0; s < SETS; s++) begin
                    tag_q[w][s]   <= '0;
                    valid_q[w][s] <= 1'b0;
                    dirty_q[w][s] <= 1'b0;
                    stamp_q[w][s] <= '0;
                    for (int k = 0; k < LINE_WORDS; k++) data_q[w][s][k] <= '0;
                end
            end
        end else begin
            ts_q  <= ts_q + 1'b1;
            hit_q <= hit_q + CNT_W'(acc_ok);
            if (accept) begin
                miss_q              <= miss_q + 1'b1;
                cnt_q               <= '0;
                way_q               <= vict;
                idx_q               <= f_idx;
                ltag_q              <= f_tag;
                vtag_q              <= tag_q[vict][f_idx];
                valid_q[vict][f_idx] <= 1'b0;
            end else if (beat) begin
                cnt_q <= last ? '0 : cnt_q + 1'b1;
                if (mem_we && last) wb_q <= wb_q + 1'b1;
                if (!mem_we) begin
                    data_q[way_q][idx_q][cnt_q] <= mem_rdata;
                    if (last) begin
                        tag_q[way_q][idx_q]   <= ltag_q;
                        valid_q[way_q][idx_q] <= 1'b1;
                        dirty_q[way_q][idx_q] <= 1'b0;
                        stamp_q[way_q][idx_q] <= ts_q;
                    end
                end
            end
            if (acc_ok) begin
                stamp_q[c_way][c_idx] <= ts_q;
                if (cpu_we) begin
                    data_q[c_way][c_idx][c_wsel] <= merged;
                    dirty_q[c_way][c_idx]        <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              abort,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [1:0]        cpu_size,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [31:0]       cpu_rdata,
    input logic              cpu_hit,
    input logic              cpu_adel,
    input logic              fill_req,
    input logic              fill_mode,
    input logic              bus_free,
    input logic              busy,
    input logic              bus_own,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rdy
);
    AST_ACCEPT_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fill_req && bus_free && !abort) |=> (busy && bus_own)); // R3
    AST_DENIED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fill_req && !bus_free) |=> !busy); // R3
    AST_INST_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fill_req && bus_free && !abort && fill_mode) |=> !mem_we); // R5
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy && !abort) |=> (mem_req && $stable(mem_addr))); // R6
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !bus_own)); // R7
    AST_LOAD_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_size == 2'd2 && cpu_addr[1:0] != 2'b00) |-> (cpu_adel && !cpu_hit)); // R8
    AST_BYTE_MISS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !cpu_hit && cpu_size == 2'd0) |-> (cpu_rdata == 32'h0000_00FF)); // R9
    AST_WORD_MISS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !cpu_hit && cpu_size == 2'd2) |-> (cpu_rdata == 32'hFFFF_FFFF)); // R9
    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !bus_own)); // R12
endmodule

bind wbc_cache wbc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .abort(abort), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit),
    .cpu_adel(cpu_adel), .fill_req(fill_req), .fill_mode(fill_mode), .bus_free(bus_free),
    .busy(busy), .bus_own(bus_own), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_rdy(mem_rdy)
);

// File: tb/sim_wbc_cache.sv
module sim_wbc_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort = 1'b0, byte_swap = 1'b0, isolate = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd2;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_hit, cpu_adel, cpu_ades;
    logic        fill_req = 1'b0, fill_mode = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        busy, bus_own, mem_req, mem_we;
    logic        bus_free = 1'b1;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_rdy = 1'b0;
    logic [31:0] hit_count, miss_count, wb_count;

    always #5 clk = ~clk;

    wbc_cache u0 (
        .clk(clk), .rst_n(rst_n), .abort(abort), .byte_swap(byte_swap), .isolate(isolate),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_adel(cpu_adel),
        .cpu_ades(cpu_ades), .fill_req(fill_req), .fill_mode(fill_mode), .fill_addr(fill_addr),
        .busy(busy), .bus_free(bus_free), .bus_own(bus_own), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .hit_count(hit_count), .miss_count(miss_count), .wb_count(wb_count)
    );

    int checks = 0, errors = 0, exp_hits = 0, exp_miss = 0;

    // memory model
    logic [31:0] mem_wr [logic [31:0]];
    logic [31:0] wr_log [$];
    logic        rdy_en = 1'b1, rdy_tgl = 1'b0;

    function automatic logic [31:0] mdef(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction
    function automatic logic [31:0] mval(input logic [31:0] a);
        return mem_wr.exists(a) ? mem_wr[a] : mdef(a);
    endfunction

    initial forever begin
        @(negedge clk);
        rdy_tgl   = rdy_en ? ~rdy_tgl : 1'b0;
        mem_rdy   = rdy_tgl;
        mem_rdata = mval(mem_addr);
        if (mem_req && mem_we && mem_rdy) begin
            mem_wr[mem_addr] = mem_wdata;
            wr_log.push_back(mem_addr);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard
    typedef struct {
        logic [31:0] rdata;
        logic        hit, adel, ades, use_data;
        string       req;
    } exp_t;
    exp_t exp_q [$];

    initial forever begin
        @(negedge clk);
        #2;
        if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.req, " hit/adel/ades"}, {29'd0, cpu_hit, cpu_adel, cpu_ades},
                {29'd0, e.hit, e.adel, e.ades});
            if (e.use_data) chk({e.req, " rdata"}, cpu_rdata, e.rdata);
        end
    end

    task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, input logic ehit, input logic [31:0] erd,
                          input string req);
        exp_t e;
        logic mis;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
        mis = (sz == 2'd2 && a[1:0] != 2'b00) || (sz == 2'd1 && a[0]);
        e.rdata = erd; e.hit = ehit; e.adel = mis && !we; e.ades = mis && we;
        e.use_data = !we; e.req = req;
        exp_q.push_back(e);
        if (ehit) exp_hits++;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic ld(input logic [1:0] sz, input logic [31:0] a, input logic ehit,
                      input logic [31:0] erd, input string req);
        access(1'b0, sz, a, 32'd0, ehit, erd, req);
    endtask

    task automatic st(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd,
                      input logic ehit, input string req);
        access(1'b1, sz, a, wd, ehit, 32'd0, req);
    endtask

    task automatic start_fill(input logic [31:0] a, input logic md, input logic iso);
        @(negedge clk);
        fill_req = 1'b1; fill_addr = a; fill_mode = md; isolate = iso;
        @(negedge clk);
        fill_req = 1'b0; isolate = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    endtask

    task automatic fill(input logic [31:0] a, input logic md, input logic iso);
        start_fill(a, md, iso);
        exp_miss++;
        wait_idle();
        chk("R7 idle after refill", {30'd0, busy, bus_own}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w100, w104;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset idle", {29'd0, busy, bus_own, mem_req}, 32'd0);
        chk("R11 reset counts", hit_count | miss_count | wb_count, 32'd0);
        ld(2'd2, 32'h100, 1'b0, 32'hFFFF_FFFF, "R9 word miss ones");
        ld(2'd0, 32'h101, 1'b0, 32'h0000_00FF, "R9 byte miss ones");
        ld(2'd1, 32'h102, 1'b0, 32'h0000_FFFF, "R9 half miss ones");

        // refill into free way
        fill(32'h104, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++)
            ld(2'd2, 32'h100 + 4*i, 1'b1, mdef(32'h100 + 4*i), "R6 refill word from line base");
        ld(2'd0, 32'h101, 1'b1, (mdef(32'h100) >> 8) & 32'hFF, "R2 byte lane 1");
        byte_swap = 1'b1;
        ld(2'd0, 32'h101, 1'b1, (mdef(32'h100) >> 16) & 32'hFF, "R2 byte lane swapped");
        ld(2'd1, 32'h102, 1'b1, mdef(32'h100) & 32'hFFFF, "R2 half lane swapped");
        byte_swap = 1'b0;
        ld(2'd1, 32'h102, 1'b1, mdef(32'h100) >> 16, "R2 half lane 1");

        // stores
        w100 = {8'h5A, mdef(32'h100)[23:0]};
        w104 = {16'h1234, mdef(32'h104)[15:0]};
        st(2'd0, 32'h103, 32'h5A, 1'b1, "R10 byte store");
        byte_swap = 1'b1;
        st(2'd1, 32'h104, 32'h1234, 1'b1, "R10 half store swapped");
        byte_swap = 1'b0;
        st(2'd2, 32'h108, 32'hDEAD_BEEF, 1'b1, "R10 word store");
        st(2'd1, 32'h101, 32'hFFFF, 1'b0, "R8 misaligned half store");
        ld(2'd2, 32'h102, 1'b0, 32'hFFFF_FFFF, "R8 misaligned word load");
        ld(2'd2, 32'h100, 1'b1, w100, "R10 R8 lane kept");
        ld(2'd2, 32'h104, 1'b1, w104, "R10 half lane only");
        ld(2'd2, 32'h108, 1'b1, 32'hDEAD_BEEF, "R10 word");

        // dropped store miss, then fill into second free way
        st(2'd2, 32'h200, 32'h0BAD_0BAD, 1'b0, "R9 store miss");
        fill(32'h200, 1'b0, 1'b0);
        ld(2'd2, 32'h200, 1'b1, mdef(32'h200), "R9 store miss dropped");
        chk("R4 free way, no write-back", wr_log.size(), 32'd0);

        // full set, clean oldest is way1
        ld(2'd2, 32'h100, 1'b1, w100, "R1 hit way0");
        fill(32'h300, 1'b0, 1'b0);
        ld(2'd2, 32'h200, 1'b0, 32'hFFFF_FFFF, "R4 oldest evicted");
        ld(2'd2, 32'h100, 1'b1, w100, "R4 newer kept");
        chk("R5 clean victim no write-back", wb_count, 32'd0);

        // dirty oldest: write-back then refill
        ld(2'd2, 32'h300, 1'b1, mdef(32'h300), "R1 hit way1");
        wr_log.delete();
        fill(32'h400, 1'b0, 1'b0);
        chk("R5 write-back count", wb_count, 32'd1);
        chk("R6 write-back beats", wr_log.size(), 32'd4);
        for (int i = 0; i < 4 && i < wr_log.size(); i++)
            chk("R6 ascending order", wr_log[i], 32'h100 + 4*i);
        chk("R5 wb word0", mval(32'h100), w100);
        chk("R5 wb word1", mval(32'h104), w104);
        chk("R5 wb word2", mval(32'h108), 32'hDEAD_BEEF);
        ld(2'd2, 32'h100, 1'b0, 32'hFFFF_FFFF, "R7 victim gone");
        ld(2'd2, 32'h40C, 1'b1, mdef(32'h40C), "R7 new line valid");

        // instruction refill skips write-back
        st(2'd2, 32'h400, 32'h1111_2222, 1'b1, "R10 dirty way0");
        ld(2'd2, 32'h300, 1'b1, mdef(32'h300), "R4 refresh way1");
        fill(32'h500, 1'b1, 1'b0);
        chk("R5 inst mode no write-back", wb_count, 32'd1);
        chk("R5 inst mode memory untouched", mval(32'h400), mdef(32'h400));

        // isolate skips write-back
        st(2'd2, 32'h500, 32'h3333_4444, 1'b1, "R10 dirty way0 again");
        ld(2'd2, 32'h300, 1'b1, mdef(32'h300), "R4 refresh way1 again");
        fill(32'h600, 1'b0, 1'b1);
        chk("R5 isolate no write-back", wb_count, 32'd1);
        chk("R5 isolate memory untouched", mval(32'h500), mdef(32'h500));

        // bus denied
        bus_free = 1'b0;
        start_fill(32'h700, 1'b0, 1'b0);
        chk("R3 bus denied ignored", {31'd0, busy}, 32'd0);
        bus_free = 1'b1;

        // refill while busy is ignored
        start_fill(32'h800, 1'b0, 1'b0);
        exp_miss++;
        start_fill(32'h900, 1'b0, 1'b0);
        wait_idle();
        ld(2'd2, 32'h900, 1'b0, 32'hFFFF_FFFF, "R3 busy refill ignored");
        ld(2'd2, 32'h800, 1'b1, mdef(32'h800), "R3 first refill done");

        // abort with stalled memory
        rdy_en = 1'b0;
        start_fill(32'hA00, 1'b0, 1'b0);
        exp_miss++;
        chk("R3 accepted busy", {30'd0, busy, bus_own}, 32'd3);
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        chk("R12 abort releases", {30'd0, busy, bus_own}, 32'd0);
        rdy_en = 1'b1;
        ld(2'd2, 32'hA00, 1'b0, 32'hFFFF_FFFF, "R12 aborted line invalid");
        ld(2'd2, 32'h600, 1'b0, 32'hFFFF_FFFF, "R7 victim invalid at accept");

        @(negedge clk);
        @(negedge clk);
        chk("R11 hit count", hit_count, exp_hits);
        chk("R11 miss count", miss_count, exp_miss);
        chk("R11 wb count", wb_count, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule